// File: doc/BRIEF.md
# Device Event Monitor

This block counts platform activity for software profiling. A 64-bit cycle counter starts on its own when reset is released and never stops. Nine 32-bit general counters each pick one event through their own select register. A single freeze bit starts and halts all nine at once. Event strobes arrive as two vectors. One vector holds reference events that any general counter may choose. The other holds per-counter lines that only their owning counter can see.

Software reaches every register over a simple word-addressed bus. A request with `we_i` low returns data one cycle later. A request with `we_i` high updates the register on the next clock. The register map is laid out as three pages chosen by address bits [5:4]:

- Page 0 holds the global control at 0x00, the cycle counter's low word at 0x01 and its high word at 0x02.
- Page 1 holds the select registers: general counter n sits at 0x10+n-1.
- Page 2 holds the counter values: general counter n sits at 0x20+n-1.

A normal session runs in four steps:

1. Clear the chosen counters.
2. Program their selects.
3. Write zero to the global control to start counting.
4. Write the freeze bit to halt, then read the results.

Top module: `pmon_top`

## Requirements
- R1: The cycle counter is 64 bits wide. It is zero during reset and then adds one on every clock, whatever the freeze bit holds.
- R2: A read of address 0x01 returns the live low word and, on the same clock, copies the high word into a shadow. A read of 0x02 returns that shadow, so a low-then-high pair is consistent.
- R3: A write to 0x01 replaces the low half of the cycle counter and a write to 0x02 replaces the high half. The counter does not increment in that cycle, and it keeps counting from the new value afterwards.
- R4: The global control at 0x00 has a freeze bit at bit 31, which resets to 1; all other bits read as 0. While freeze is 1 the general counters hold their values. Writing 0x0 starts them.
- R5: Each select register keeps bits [6:0], resets to 0, and reads its other bits as 0.
- R6: A select value s below the number of reference lines (32) makes the counter add one on each clock that `evt_ref_i[s]` is high.
- R7: A select value of 64+k, with k below 4, makes general counter n count `evt_spec_i[(n-1)*4+k]`, a line that belongs to that counter alone. Every other select value counts nothing.
- R8: A write to a general counter loads the written value, even in a cycle where its event is active.
- R9: A general counter wraps from 0xFFFFFFFF to 0 without any other effect.
- R10: Read data and `rvalid_o` appear one clock after a read request. Unmapped addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Platform clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| evt_ref_i | input | N_REF | Reference event strobes |
| evt_spec_i | input | NUM_GEN*N_SPEC | Per-counter event strobes |

## Verification
The hardest behaviour to reach from the ports is the carry from the low word into the high word of the cycle counter. Counting there from reset would take about 2^32 clocks. The stimulus avoids this by loading the high half and then a low value just below the wrap point. It reads the low word just before the carry and the high word just after it. The high-word read must still return the value from before the carry, and a fresh pair of reads must then show the incremented high word. The general counters face the same problem at their wrap and at the write-versus-event collision. Both are reached by preloading the counter through the bus while an event strobe is held high.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned SEL_W     = 7;
  localparam int unsigned SPEC_BASE = 64;
  localparam int unsigned FRZ_BIT   = 31;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [1:0] {
    PAGE_GLOB = 2'd0,
    PAGE_LCTL = 2'd1,
    PAGE_CNT  = 2'd2,
    PAGE_NONE = 2'd3
  } page_e;

  localparam logic [3:0] OFS_GCTL   = 4'd0;
  localparam logic [3:0] OFS_CYC_LO = 4'd1;
  localparam logic [3:0] OFS_CYC_HI = 4'd2;
endpackage

// File: rtl/pmon_addr_dec.sv
module pmon_addr_dec
  import pmon_pkg::*;
#(
  parameter int unsigned NUM_GEN = 9
) (
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output page_e                   page_o,
  output logic [3:0]              ofs_o,
  output logic                    rd_o,
  output logic                    gctl_wr_o,
  output logic                    cyc_lo_wr_o,
  output logic                    cyc_hi_wr_o,
  output logic                    cyc_lo_rd_o,
  output logic [NUM_GEN-1:0]      lctl_wr_o,
  output logic [NUM_GEN-1:0]      cnt_wr_o
);
  logic wr;

  assign page_o = page_e'(addr_i[5:4]);
  assign ofs_o  = addr_i[3:0];
  assign wr     = req_i && we_i;
  assign rd_o   = req_i && !we_i;

  assign gctl_wr_o   = wr && (page_o == PAGE_GLOB) && (ofs_o == OFS_GCTL);
  assign cyc_lo_wr_o = wr && (page_o == PAGE_GLOB) && (ofs_o == OFS_CYC_LO);
  assign cyc_hi_wr_o = wr && (page_o == PAGE_GLOB) && (ofs_o == OFS_CYC_HI);
  assign cyc_lo_rd_o = rd_o && (page_o == PAGE_GLOB) && (ofs_o == OFS_CYC_LO);

  for (genvar n = 0; n < NUM_GEN; n++) begin : g_dec
    assign lctl_wr_o[n] = wr && (page_o == PAGE_LCTL) && (ofs_o == 4'(n));
    assign cnt_wr_o[n]  = wr && (page_o == PAGE_CNT)  && (ofs_o == 4'(n));
  end
endmodule

// File: rtl/pmon_cycle_ctr.sv
module pmon_cycle_ctr
  import pmon_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic                rd_lo_i,
  input  word_t               wdata_i,
  output logic [2*DATA_W-1:0] cnt_o,
  output word_t               shadow_o
);
  logic [2*DATA_W-1:0] cnt_q;
  word_t               shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q <= {cnt_q[2*DATA_W-1:DATA_W], wdata_i};
    end else if (wr_hi_i) begin
      cnt_q <= {wdata_i, cnt_q[DATA_W-1:0]};
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // low-word read freezes the matching high word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (rd_lo_i) shadow_q <= cnt_q[2*DATA_W-1:DATA_W];
  end

  assign cnt_o    = cnt_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/pmon_event_sel.sv
module pmon_event_sel
  import pmon_pkg::*;
#(
  parameter int unsigned N_REF  = 32,
  parameter int unsigned N_SPEC = 4
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [N_REF-1:0]  evt_ref_i,
  input  logic [N_SPEC-1:0] evt_spec_i,
  output logic              hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < N_REF; i++) begin
      if (sel_i == SEL_W'(i)) hit_o = evt_ref_i[i];
    end
    for (int k = 0; k < N_SPEC; k++) begin
      if (sel_i == SEL_W'(SPEC_BASE + k)) hit_o = evt_spec_i[k];
    end
  end
endmodule

// File: rtl/pmon_gen_ctr.sv
module pmon_gen_ctr
  import pmon_pkg::*;
#(
  parameter int unsigned N_REF  = 32,
  parameter int unsigned N_SPEC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              lctl_wr_i,
  input  logic              cnt_wr_i,
  input  word_t             wdata_i,
  input  logic [N_REF-1:0]  evt_ref_i,
  input  logic [N_SPEC-1:0] evt_spec_i,
  output logic [SEL_W-1:0]  sel_o,
  output word_t             cnt_o
);
  logic [SEL_W-1:0] sel_q;
  word_t            cnt_q;
  logic             hit;

  pmon_event_sel #(.N_REF(N_REF), .N_SPEC(N_SPEC)) u_sel (
    .sel_i      (sel_q),
    .evt_ref_i  (evt_ref_i),
    .evt_spec_i (evt_spec_i),
    .hit_o      (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= '0;
    else if (lctl_wr_i) sel_q <= wdata_i[SEL_W-1:0];
  end

  // bus write wins over a same-cycle event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_wr_i)      cnt_q <= wdata_i;
    else if (run_i && hit)  cnt_q <= cnt_q + 1'b1;
  end

  assign sel_o = sel_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmon_top.sv
module pmon_top
  import pmon_pkg::*;
#(
  parameter int unsigned NUM_GEN = 9,
  parameter int unsigned N_REF   = 32,
  parameter int unsigned N_SPEC  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o,
  input  logic [N_REF-1:0]          evt_ref_i,
  input  logic [NUM_GEN*N_SPEC-1:0] evt_spec_i
);
  page_e                           page;
  logic [3:0]                      ofs;
  logic                            rd, gctl_wr, cyc_lo_wr, cyc_hi_wr, cyc_lo_rd;
  logic [NUM_GEN-1:0]              lctl_wr, cnt_wr;
  logic [2*DATA_W-1:0]             cyc_cnt;
  word_t                           cyc_shadow;
  logic                            freeze_q;
  logic [NUM_GEN-1:0][DATA_W-1:0]  gen_cnt;
  logic [NUM_GEN-1:0][SEL_W-1:0]   sel_vec;
  word_t                           rd_mux, rdata_q;
  logic                            rvalid_q;

  pmon_addr_dec #(.NUM_GEN(NUM_GEN)) u_dec (
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .page_o      (page),
    .ofs_o       (ofs),
    .rd_o        (rd),
    .gctl_wr_o   (gctl_wr),
    .cyc_lo_wr_o (cyc_lo_wr),
    .cyc_hi_wr_o (cyc_hi_wr),
    .cyc_lo_rd_o (cyc_lo_rd),
    .lctl_wr_o   (lctl_wr),
    .cnt_wr_o    (cnt_wr)
  );

  pmon_cycle_ctr u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_lo_i  (cyc_lo_wr),
    .wr_hi_i  (cyc_hi_wr),
    .rd_lo_i  (cyc_lo_rd),
    .wdata_i  (wdata_i),
    .cnt_o    (cyc_cnt),
    .shadow_o (cyc_shadow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      freeze_q <= 1'b1;
    else if (gctl_wr) freeze_q <= wdata_i[FRZ_BIT];
  end

  for (genvar n = 0; n < NUM_GEN; n++) begin : g_ctr
    pmon_gen_ctr #(.N_REF(N_REF), .N_SPEC(N_SPEC)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (!freeze_q),
      .lctl_wr_i  (lctl_wr[n]),
      .cnt_wr_i   (cnt_wr[n]),
      .wdata_i    (wdata_i),
      .evt_ref_i  (evt_ref_i),
      .evt_spec_i (evt_spec_i[n*N_SPEC +: N_SPEC]),
      .sel_o      (sel_vec[n]),
      .cnt_o      (gen_cnt[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (page)
      PAGE_GLOB: begin
        case (ofs)
          OFS_GCTL:   rd_mux[FRZ_BIT] = freeze_q;
          OFS_CYC_LO: rd_mux = cyc_cnt[DATA_W-1:0];
          OFS_CYC_HI: rd_mux = cyc_shadow;
          default:    rd_mux = '0;
        endcase
      end
      PAGE_LCTL: begin
        for (int n = 0; n < NUM_GEN; n++) begin
          if (ofs == 4'(n)) rd_mux[SEL_W-1:0] = sel_vec[n];
        end
      end
      PAGE_CNT: begin
        for (int n = 0; n < NUM_GEN; n++) begin
          if (ofs == 4'(n)) rd_mux = gen_cnt[n];
        end
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/pmon_chk.sv
module pmon_chk #(
  parameter int unsigned NUM_GEN = 9
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic                      we_i,
  input logic [5:0]                addr_i,
  input logic [31:0]               wdata_i,
  input logic                      rvalid_o,
  input logic [63:0]               cyc_cnt,
  input logic [31:0]               cyc_shadow,
  input logic                      freeze_q,
  input logic [NUM_GEN-1:0][31:0]  gen_cnt
);
  logic cyc_wr, cnt_wr_any, rd_req;

  assign cyc_wr     = req_i && we_i && (addr_i == 6'h01 || addr_i == 6'h02);
  assign cnt_wr_any = req_i && we_i && (addr_i[5:4] == 2'b10);
  assign rd_req     = req_i && !we_i;

  // R1
  cyc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_wr |=> cyc_cnt == $past(cyc_cnt) + 64'd1);

  // R2
  shadow_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i == 6'h01) |=> cyc_shadow == $past(cyc_cnt[63:32]));

  // R4
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_q && !cnt_wr_any) |=> $stable(gen_cnt));

  // R10
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);

  for (genvar n = 0; n < NUM_GEN; n++) begin : g_wr
    // R8
    wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == (6'h20 + 6'(n))) |=> gen_cnt[n] == $past(wdata_i));
  end
endmodule

bind pmon_top pmon_chk #(.NUM_GEN(NUM_GEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rvalid_o   (rvalid_o),
  .cyc_cnt    (cyc_cnt),
  .cyc_shadow (cyc_shadow),
  .freeze_q   (freeze_q),
  .gen_cnt    (gen_cnt)
);

// File: tb/sim_pmon_top.sv
module sim_pmon_top;
  localparam int NUM_GEN = 9;
  localparam int N_REF   = 32;
  localparam int N_SPEC  = 4;
  localparam int SPW     = NUM_GEN * N_SPEC;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0, we = 1'b0;
  logic [5:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             rvalid;
  logic [N_REF-1:0] evt_ref = '0;
  logic [SPW-1:0]   evt_spec = '0;

  int checks = 0, fails = 0;
  logic [63:0] cyc_m;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  pmon_top #(.NUM_GEN(NUM_GEN), .N_REF(N_REF), .N_SPEC(N_SPEC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .evt_ref_i(evt_ref), .evt_spec_i(evt_spec)
  );

  // cycle counter reference model from R1/R3
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_m <= '0;
    else if (req && we && addr == 6'h01) cyc_m[31:0] <= wdata;
    else if (req && we && addr == 6'h02) cyc_m[63:32] <= wdata;
    else cyc_m <= cyc_m + 64'd1;
  end

  // monitor
  always @(negedge clk) begin
    if (rvalid) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected rvalid, got %h expected none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [5:0] lctl_a(int n); return 6'(16 + n - 1); endfunction
  function automatic logic [5:0] cnt_a(int n);  return 6'(32 + n - 1); endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    sb_q.push_back('{exp: e, tag: tag});
    @(negedge clk); req = 0;
  endtask

  task automatic rd_lo(input string tag, output logic [31:0] hi_snap);
    @(negedge clk); req = 1; we = 0; addr = 6'h01;
    sb_q.push_back('{exp: cyc_m[31:0], tag: tag});
    hi_snap = cyc_m[63:32];
    @(negedge clk); req = 0;
  endtask

  task automatic pulse(input logic [N_REF-1:0] r, input logic [SPW-1:0] s, input int n);
    @(negedge clk); evt_ref = r; evt_spec = s;
    repeat (n) @(negedge clk);
    evt_ref = '0; evt_spec = '0;
  endtask

  task automatic direct(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] hs, hs2;
    repeat (3) @(negedge clk);
    direct(rdata === 32'h0 && rvalid === 1'b0, "R10 reset outputs", {rdata[31:1], rvalid}, 32'h0);
    rst_n = 1;
    // reset state
    rd(6'h00, 32'h8000_0000, "R4 freeze reset");
    rd(cnt_a(1), 32'h0, "R9 counter reset");
    rd(lctl_a(1), 32'h0, "R5 select reset");
    rd_lo("R1 cycle after reset", hs);
    rd(6'h3F, 32'h0, "R10 unmapped read");

    // program selects while frozen
    wr(lctl_a(1), 32'd3);
    wr(lctl_a(2), 32'd10);
    wr(lctl_a(3), 32'd65);
    wr(lctl_a(4), 32'd65);
    wr(lctl_a(5), 32'd100);
    wr(lctl_a(9), 32'd67);
    pulse(32'h8, '0, 5);
    rd(cnt_a(1), 32'd0, "R4 frozen holds");
    rd_lo("R1 counts while frozen", hs);

    wr(6'h00, 32'h0); // start
    pulse(32'h8, '0, 7);
    rd(cnt_a(1), 32'd7, "R6 ref event 3");
    pulse(32'h400, '0, 4);
    rd(cnt_a(2), 32'd4, "R6 ref event 10");
    rd(cnt_a(1), 32'd7, "R6 other line ignored");
    pulse('0, SPW'(1) << 9, 6);
    rd(cnt_a(3), 32'd6, "R7 own specific line");
    rd(cnt_a(4), 32'd0, "R7 neighbour line ignored");
    pulse('0, SPW'(1) << 35, 2);
    rd(cnt_a(9), 32'd2, "R7 counter 9 specific");
    pulse('1, '1, 3);
    rd(cnt_a(5), 32'd0, "R7 unused select counts nothing");
    rd(cnt_a(1), 32'd10, "R6 all-high pulse");
    rd(cnt_a(4), 32'd3, "R7 all-high pulse");

    // R8: write collides with an active event
    @(negedge clk); evt_ref = 32'h8; req = 1; we = 1; addr = cnt_a(1); wdata = 32'd100;
    @(negedge clk); req = 0; we = 0;
    repeat (5) @(negedge clk);
    evt_ref = '0;
    rd(cnt_a(1), 32'd105, "R8 write over increment");

    // R9 wrap
    wr(cnt_a(2), 32'hFFFF_FFFF);
    pulse(32'h400, '0, 2);
    rd(cnt_a(2), 32'd1, "R9 wrap to zero");

    // R5 field width
    wr(lctl_a(6), 32'hFFFF_FF85);
    rd(lctl_a(6), 32'h0000_0005, "R5 select field only");

    // R10 unmapped write ignored
    wr(6'h3F, 32'hDEAD_BEEF);
    rd(6'h3F, 32'h0, "R10 unmapped write");
    rd(6'h03, 32'h0, "R10 unmapped global slot");

    // R4 other bits read zero, then freeze
    wr(6'h00, 32'h7FFF_FFFF);
    rd(6'h00, 32'h0, "R4 reserved bits zero");
    wr(6'h00, 32'h8000_0000);
    rd(6'h00, 32'h8000_0000, "R4 freeze set");
    pulse(32'h8, '0, 4);
    rd(cnt_a(1), 32'd105, "R4 halted after freeze");

    // R3/R2 cycle counter carry and shadow
    wr(6'h02, 32'd5);
    wr(6'h01, 32'hFFFF_FFF0);
    rd_lo("R3 low half loaded", hs);
    rd(6'h02, hs, "R2 shadow high before carry");
    direct(hs === 32'd5, "R3 high half loaded", hs, 32'd5);
    repeat (30) @(negedge clk);
    rd(6'h02, 32'd5, "R2 shadow held across carry");
    rd_lo("R1 low after carry", hs2);
    rd(6'h02, hs2, "R2 high after carry");
    direct(hs2 === 32'd6, "R1 carry into high word", hs2, 32'd6);

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10: got %0d pending reads expected 0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule